// File: doc/BRIEF.md
# Modulo 2^n−1 Prefix Adder with Excess-One Correction

This block adds two n-bit residues modulo 2^n − 1 in a single combinational pass. It is meant as an arithmetic channel inside a residue-number datapath, for example in the stage that turns residues back into binary. Each operand lies between 0 and 2^n − 2. The result is the n-bit modular sum, always in that same range.

The design has two stages. The first is a Kogge-Stone parallel-prefix adder. Bitwise generate and propagate signals are formed first, then merged over log2(n) levels of the prefix tree, and finally combined into a raw sum with carry-in tied to zero. The second stage is an excess-one unit. It adds one to the raw sum when a correction flag from the tree is set. That flag is the group generate of the full width ORed with the group propagate of the full width. It is therefore high when the raw addition carries out, or when the raw sum is all ones. The carry out of the increment is dropped, which completes the wrap. Because the all-ones code is folded into zero, zero has a single representation.

The block has no clock, no state and no state machine. The width parameter `WIDTH` defaults to 5 and must be at least 2.

Top module: `mod_m1_adder`

## Requirements
- R1: For every pair of operands in 0..2^WIDTH−2, `mod_sum` equals (opnd_a + opnd_b) mod (2^WIDTH − 1).
- R2: For legal operands, `mod_sum` never takes the all-ones value 2^WIDTH − 1.
- R3: When opnd_a + opnd_b equals exactly 2^WIDTH − 1, `mod_sum` is 0. In this case the raw sum is all ones, and it is folded to zero.
- R4: When opnd_a + opnd_b is below 2^WIDTH − 1, `mod_sum` equals the plain binary sum and no increment is applied.
- R5: When opnd_a + opnd_b is at least 2^WIDTH, `mod_sum` equals opnd_a + opnd_b − 2^WIDTH + 1, and it is strictly smaller than both operands.
- R6: Zero is the identity: 0 + 0 gives 0, and x + 0 or 0 + x gives x.
- R7: The output depends only on the current inputs and follows an input change with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | WIDTH | First residue, 0..2^WIDTH−2 |
| opnd_b | input | WIDTH | Second residue, 0..2^WIDTH−2 |
| mod_sum | output | WIDTH | Modular sum, 0..2^WIDTH−2 |

## Verification
The adder is first swept over every legal operand pair and compared with a modulo computed in the bench. This alone proves functional equality and the absence of the all-ones code. Directed groups then isolate each of the three internal paths:
- Pairs whose sum is exactly the modulus exercise only the group-propagate trigger.
- Pairs whose sum overflows exercise only the group-generate trigger.
- Pairs whose sum stays below the modulus must pass through without any increment.

A mistake in any one trigger therefore appears in its own group. Identity pairs and input changes made without a clock edge confirm that the path is purely combinational.

// File: rtl/mma_pkg.sv
package mma_pkg;
    // number of Kogge-Stone levels needed to span w bits
    function automatic int prefix_levels(input int w);
        int lv;
        lv = 0;
        while ((1 << lv) < w) lv++;
        return lv;
    endfunction
endpackage

// File: rtl/mma_prefix_tree.sv
module mma_prefix_tree #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    output logic [WIDTH-1:0] raw_sum,
    output logic             grp_gen,
    output logic             grp_prop
);
    localparam int LVL = mma_pkg::prefix_levels(WIDTH);

    logic [LVL:0][WIDTH-1:0] gl;
    logic [LVL:0][WIDTH-1:0] pl;

    // pre-processing, prefix carry tree, post-processing
    always_comb begin
        gl[0] = x & y;
        pl[0] = x ^ y;
        for (int lv = 0; lv < LVL; lv++) begin
            for (int i = 0; i < WIDTH; i++) begin
                if (i >= (1 << lv)) begin
                    gl[lv+1][i] = gl[lv][i] | (pl[lv][i] & gl[lv][i-(1<<lv)]);
                    pl[lv+1][i] = pl[lv][i] & pl[lv][i-(1<<lv)];
                end else begin
                    gl[lv+1][i] = gl[lv][i];
                    pl[lv+1][i] = pl[lv][i];
                end
            end
        end
        raw_sum  = pl[0] ^ {gl[LVL][WIDTH-2:0], 1'b0};
        grp_gen  = gl[LVL][WIDTH-1];
        grp_prop = pl[LVL][WIDTH-1];
    end

    // carry-out and an all-ones raw sum cannot occur together (R3/R5 triggers disjoint)
    always_comb begin
        if (!$isunknown({x, y})) begin
            assert_triggers_disjoint_R5: assert (!(grp_gen && grp_prop))
                else $error("prefix tree raised generate and propagate together");
        end
    end
endmodule

// File: rtl/mma_incr.sv
module mma_incr #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] sum_in,
    input  logic             inc_en,
    output logic [WIDTH-1:0] sum_out
);
    logic [WIDTH-1:0] toggle;

    // toggle[i] = AND of all sum bits below i; the carry beyond the MSB is dropped
    always_comb begin
        toggle[0] = 1'b1;
        for (int i = 1; i < WIDTH; i++) begin
            toggle[i] = toggle[i-1] & sum_in[i-1];
        end
        sum_out = sum_in ^ ({WIDTH{inc_en}} & toggle);
    end

    always_comb begin
        if (!$isunknown({sum_in, inc_en}) && !inc_en) begin
            assert_idle_pass_R4: assert (sum_out == sum_in)
                else $error("increment applied without request");
        end
    end
endmodule

// File: rtl/mod_m1_adder.sv
module mod_m1_adder #(
    parameter int WIDTH = 5
) (
    input  logic [WIDTH-1:0] opnd_a,
    input  logic [WIDTH-1:0] opnd_b,
    output logic [WIDTH-1:0] mod_sum
);
    localparam logic [WIDTH-1:0] ALL1 = '1;

    logic [WIDTH-1:0] raw_sum;
    logic             grp_gen;
    logic             grp_prop;
    logic             corr_en;

    mma_prefix_tree #(.WIDTH(WIDTH)) u_tree (
        .x        (opnd_a),
        .y        (opnd_b),
        .raw_sum  (raw_sum),
        .grp_gen  (grp_gen),
        .grp_prop (grp_prop)
    );

    assign corr_en = grp_gen | grp_prop;

    mma_incr #(.WIDTH(WIDTH)) u_incr (
        .sum_in  (raw_sum),
        .inc_en  (corr_en),
        .sum_out (mod_sum)
    );

    always_comb begin
        if (!$isunknown({opnd_a, opnd_b}) && opnd_a != ALL1 && opnd_b != ALL1) begin
            assert_no_all_ones_R2: assert (mod_sum != ALL1)
                else $error("all-ones result produced");
            if (grp_prop) begin
                assert_cancel_zero_R3: assert (mod_sum == '0)
                    else $error("modulus sum not folded to zero");
            end
            if (grp_gen) begin
                assert_wrap_below_R5: assert (mod_sum < opnd_a && mod_sum < opnd_b)
                    else $error("wrapped sum not below operands");
            end
            if (!corr_en) begin
                assert_plain_sum_R4: assert (mod_sum == opnd_a + opnd_b)
                    else $error("uncorrected sum differs from binary sum");
            end
        end
    end
endmodule

// File: tb/tb_mod_m1_adder.sv
module tb_mod_m1_adder;
    localparam int W = 5;
    localparam int M = (1 << W) - 1;

    logic clk = 1'b0;
    logic [W-1:0] opnd_a, opnd_b;
    logic [W-1:0] mod_sum;
    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 0;

    always #5 clk = ~clk;

    mod_m1_adder #(.WIDTH(W)) dut (.opnd_a(opnd_a), .opnd_b(opnd_b), .mod_sum(mod_sum));

    task automatic check(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: a=%0d b=%0d got %0d expected %0d", req, opnd_a, opnd_b, got, exp);
        end
    endtask

    task automatic apply(input int a, input int b);
        @(negedge clk);
        opnd_a = W'(a);
        opnd_b = W'(b);
        #1;
    endtask

    task automatic t_reset_state;
        apply(0, 0);
        check("R6 zero pair", int'(mod_sum), 0);
    endtask

    task automatic t_exhaustive;
        for (int a = 0; a < M; a++) begin
            for (int b = 0; b < M; b++) begin
                opnd_a = W'(a);
                opnd_b = W'(b);
                #1;
                check("R1", int'(mod_sum), (a + b) % M);
                checks++;
                if (int'(mod_sum) == M) begin
                    fails++;
                    $display("FAIL R2: a=%0d b=%0d got %0d expected not %0d", a, b, mod_sum, M);
                end
            end
        end
    endtask

    task automatic t_complement;
        for (int a = 0; a < M; a++) begin
            apply(a, M - a > M - 1 ? M - 1 : M - a);
            if (a != 0) check("R3 complement", int'(mod_sum), 0);
        end
    endtask

    task automatic t_no_carry;
        apply(3, 4);   check("R4", int'(mod_sum), 7);
        apply(16, 14); check("R4", int'(mod_sum), 30);
        apply(10, 5);  check("R4", int'(mod_sum), 15);
    endtask

    task automatic t_carry;
        apply(30, 30); check("R5", int'(mod_sum), 29);
        apply(16, 16); check("R5", int'(mod_sum), 1);
        apply(17, 15); check("R5", int'(mod_sum), 1);
        apply(20, 25); check("R5", int'(mod_sum), 14);
    endtask

    task automatic t_identity;
        apply(19, 0); check("R6", int'(mod_sum), 19);
        apply(0, 30); check("R6", int'(mod_sum), 30);
    endtask

    task automatic t_no_edge;
        @(posedge clk);
        #1;
        opnd_a = W'(9); opnd_b = W'(8);
        #1; check("R7", int'(mod_sum), 17);
        opnd_a = W'(25); opnd_b = W'(8);
        #1; check("R7", int'(mod_sum), 2);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            done = 1;
            fails++;
            checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        opnd_a = '0;
        opnd_b = '0;
        t_reset_state();
        t_exhaustive();
        t_complement();
        t_no_carry();
        t_carry();
        t_identity();
        t_no_edge();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule